// File: doc/BRIEF.md
# Filtered Event Counter Slice

This block is one slice of a performance-monitoring unit. A bank of event sources delivers, every cycle, a small vector of sub-event hit bits per source. Software programs a 64-bit control word that picks one source, masks its sub-event bits, and sets how the per-cycle increment is shaped. The increment can be added as is, reduced to one qualified pulse per cycle by a threshold compare (optionally strict), or further reduced to one count per rising edge of that qualified condition. The shaped value is accumulated in a 48-bit counter.

Counting runs only while the slice's own enable bit and the global enable input are both high. When the counter carries out of its top bit, it wraps and keeps counting, and, if enabled, emits a one-cycle interrupt pulse toward the global freeze logic. Software can preload the counter with 2^48 - N so that the pulse arrives after N events. Both registers can be read at any time through a combinational read port, including while counting.

Top module: `pmon_slice`

## Requirements
- R1: After reset the control word and the counter both read as zero and irq_o is low.
- R2: A control write keeps only these fields: event code bits 7:0, sub-event mask 15:8, edge mode bit 18, interrupt enable bit 20, local enable bit 22, strict-compare bit 23, threshold 31:24. All other bits (63:32, 21, 19, 17:16) read as zero, so writing all ones reads back 0x00000000FFD4FFFF.
- R3: Event code k below N_EVT selects evt_vec_i[k*SUB_W +: SUB_W]; the raw increment is the number of set bits in that slice ANDed with the mask. A code of N_EVT or more gives a raw increment of zero.
- R4: With threshold zero and edge mode off, the raw increment is added every counting cycle, whatever the strict-compare bit holds.
- R5: With a nonzero threshold and strict-compare clear, the counter advances by exactly one in a cycle whose raw increment is greater than or equal to the threshold, and by zero otherwise.
- R6: With a nonzero threshold and strict-compare set, the counter advances by one only when the raw increment is strictly greater than the threshold.
- R7: With edge mode on, the counter advances by one only in a cycle where the qualified condition (raw increment nonzero when the threshold is zero, else the compare of R5/R6) is true and was false in the previous cycle; the condition history is tracked every cycle.
- R8: The counter holds its value unless both the local enable bit and glb_en_i are high.
- R9: The counter wraps modulo 2^48 and keeps counting after the wrap.
- R10: A carry out of bit 47 produces a single-cycle pulse on irq_o, visible in the same cycle as the wrapped counter value, only when the interrupt enable bit is set.
- R11: A software write to the counter takes priority over an increment in the same cycle; that cycle neither counts nor raises irq_o.
- R12: rd_data_o shows the control word when rd_sel_i is 0 and the counter, zero-extended, when rd_sel_i is 1, with counting left undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| glb_en_i | input | 1 | Global count enable from the freeze controller |
| evt_vec_i | input | N_EVT*SUB_W (32) | Per-source sub-event hit vectors, source k in slice k |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control word, 1 counter |
| wr_data_i | input | 64 | Write data |
| rd_sel_i | input | 1 | Read target: 0 control word, 1 counter |
| rd_data_o | output | 64 | Read data, combinational |
| irq_o | output | 1 | One-cycle overflow interrupt pulse |

## Verification
Two actions compete for the counter in one cycle: a software load and an enabled increment, and the increment may itself be the one that carries out of bit 47. The bench preloads the counter to its maximum, then in a single cycle raises the global enable with a nonzero event and also writes a small value; it expects the written value afterwards with irq_o low, and the following cycle the written value plus the increment. Overflow alone is judged cycle by cycle against the wrapped value and the pulse position.

// File: rtl/pmon_pkg.sv
`timescale 1ns/1ps
package pmon_pkg;

   localparam int unsigned CFG_W    = 64;
   localparam int unsigned CODE_W   = 8;
   localparam int unsigned MASK_W   = 8;
   localparam int unsigned THR_W    = 8;

   // Bit positions of the control word (software-visible layout)
   localparam int unsigned CODE_LSB = 0;
   localparam int unsigned MASK_LSB = 8;
   localparam int unsigned EDGE_BIT = 18;
   localparam int unsigned IRQ_BIT  = 20;
   localparam int unsigned EN_BIT   = 22;
   localparam int unsigned INV_BIT  = 23;
   localparam int unsigned THR_LSB  = 24;

   typedef struct packed {
      logic [THR_W-1:0]  thr;
      logic              inv;
      logic              en;
      logic              irq_en;
      logic              edge_on;
      logic [MASK_W-1:0] mask;
      logic [CODE_W-1:0] code;
   } cfg_t;

   function automatic cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
      cfg_t c;
      c.code    = w[CODE_LSB +: CODE_W];
      c.mask    = w[MASK_LSB +: MASK_W];
      c.edge_on = w[EDGE_BIT];
      c.irq_en  = w[IRQ_BIT];
      c.en      = w[EN_BIT];
      c.inv     = w[INV_BIT];
      c.thr     = w[THR_LSB +: THR_W];
      return c;
   endfunction

   function automatic logic [CFG_W-1:0] cfg_pack(input cfg_t c);
      logic [CFG_W-1:0] w;
      w = '0;
      w[CODE_LSB +: CODE_W] = c.code;
      w[MASK_LSB +: MASK_W] = c.mask;
      w[EDGE_BIT]           = c.edge_on;
      w[IRQ_BIT]            = c.irq_en;
      w[EN_BIT]             = c.en;
      w[INV_BIT]            = c.inv;
      w[THR_LSB +: THR_W]   = c.thr;
      return w;
   endfunction

endpackage

// File: rtl/pmon_cfg_reg.sv
`timescale 1ns/1ps
module pmon_cfg_reg
   import pmon_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  logic [CFG_W-1:0] wdata_i,
   output cfg_t             cfg_o,
   output logic [CFG_W-1:0] raw_o
);

   cfg_t cfg_q;

   // Only defined fields have storage; all else reads as zero.
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cfg_q <= '0;
      end else if (wr_i) begin
         cfg_q <= cfg_unpack(wdata_i);
      end
   end

   assign cfg_o = cfg_q;
   assign raw_o = cfg_pack(cfg_q);

endmodule

// File: rtl/pmon_evt_sel.sv
`timescale 1ns/1ps
module pmon_evt_sel
   import pmon_pkg::*;
#(
   parameter int unsigned N_EVT = 4,
   parameter int unsigned SUB_W = 8,
   parameter int unsigned INC_W = $clog2(SUB_W + 1)
)(
   input  logic [N_EVT*SUB_W-1:0] evt_vec_i,
   input  logic [CODE_W-1:0]      code_i,
   input  logic [MASK_W-1:0]      mask_i,
   output logic [INC_W-1:0]       inc_o
);

   logic [N_EVT*INC_W-1:0] pc_flat;

   // One masked population count per event source
   for (genvar g = 0; g < N_EVT; g++) begin : g_evt
      logic [SUB_W-1:0] hits;
      logic [INC_W-1:0] cnt;
      assign hits = evt_vec_i[g*SUB_W +: SUB_W] & mask_i[SUB_W-1:0];
      always_comb begin
         cnt = '0;
         for (int b = 0; b < SUB_W; b++) begin
            cnt = cnt + INC_W'(hits[b]);
         end
      end
      assign pc_flat[g*INC_W +: INC_W] = cnt;
   end

   if (N_EVT == 1) begin : g_single
      assign inc_o = (code_i == '0) ? pc_flat : '0;
   end else begin : g_mux
      always_comb begin
         inc_o = '0;
         for (int i = 0; i < N_EVT; i++) begin
            if (code_i == CODE_W'(i)) begin
               inc_o = pc_flat[i*INC_W +: INC_W];
            end
         end
      end
   end

endmodule

// File: rtl/pmon_filter.sv
`timescale 1ns/1ps
module pmon_filter
   import pmon_pkg::*;
#(
   parameter int unsigned INC_W = 4
)(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [INC_W-1:0] inc_i,
   input  logic [THR_W-1:0] thr_i,
   input  logic             inv_i,
   input  logic             edge_on_i,
   output logic [INC_W-1:0] step_o
);

   localparam int unsigned CMP_W = (THR_W > INC_W) ? THR_W : INC_W;

   logic [CMP_W-1:0] inc_x;
   logic [CMP_W-1:0] thr_x;
   logic             thr_zero;
   logic             hit;
   logic             hit_q;

   assign inc_x    = CMP_W'(inc_i);
   assign thr_x    = CMP_W'(thr_i);
   assign thr_zero = (thr_i == '0);

   // Stage 1: threshold compare, inclusive or strict
   always_comb begin
      if (thr_zero) begin
         hit = (inc_i != '0);
      end else if (inv_i) begin
         hit = (thr_x < inc_x);
      end else begin
         hit = (thr_x <= inc_x);
      end
   end

   // History of the qualified condition, kept every cycle
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         hit_q <= 1'b0;
      end else begin
         hit_q <= hit;
      end
   end

   // Stage 2: optional rising-edge reduction
   always_comb begin
      if (edge_on_i) begin
         step_o = INC_W'(hit && !hit_q);
      end else if (thr_zero) begin
         step_o = inc_i;
      end else begin
         step_o = INC_W'(hit);
      end
   end

endmodule

// File: rtl/pmon_counter.sv
`timescale 1ns/1ps
module pmon_counter #(
   parameter int unsigned CTR_W = 48,
   parameter int unsigned INC_W = 4
)(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  logic [CTR_W-1:0] wdata_i,
   input  logic             cnt_en_i,
   input  logic [INC_W-1:0] step_i,
   input  logic             irq_en_i,
   output logic [CTR_W-1:0] ctr_o,
   output logic             irq_o
);

   logic [CTR_W-1:0] ctr_q;
   logic [CTR_W:0]   sum;
   logic             carry;
   logic             irq_q;

   assign sum   = {1'b0, ctr_q} + {{(CTR_W + 1 - INC_W){1'b0}}, step_i};
   assign carry = cnt_en_i && !wr_i && sum[CTR_W];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ctr_q <= '0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= carry && irq_en_i;
         if (wr_i) begin
            ctr_q <= wdata_i;
         end else if (cnt_en_i) begin
            ctr_q <= sum[CTR_W-1:0];
         end
      end
   end

   assign ctr_o = ctr_q;
   assign irq_o = irq_q;

endmodule

// File: rtl/pmon_slice.sv
`timescale 1ns/1ps
module pmon_slice
   import pmon_pkg::*;
#(
   parameter int unsigned N_EVT = 4,
   parameter int unsigned SUB_W = 8,
   parameter int unsigned CTR_W = 48
)(
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   glb_en_i,
   input  logic [N_EVT*SUB_W-1:0] evt_vec_i,
   input  logic                   wr_en_i,
   input  logic                   wr_sel_i,
   input  logic [CFG_W-1:0]       wr_data_i,
   input  logic                   rd_sel_i,
   output logic [CFG_W-1:0]       rd_data_o,
   output logic                   irq_o
);

   localparam int unsigned INC_W = $clog2(SUB_W + 1);

   // Elaboration-time parameter checks
   if (CTR_W > CFG_W) begin : g_bad_ctr_w
      $error("pmon_slice: CTR_W exceeds the register width");
   end
   if (CTR_W <= INC_W) begin : g_bad_ctr_small
      $error("pmon_slice: CTR_W too small for the increment");
   end
   if (SUB_W > MASK_W || SUB_W == 0) begin : g_bad_sub_w
      $error("pmon_slice: SUB_W must be 1..MASK_W");
   end
   if (N_EVT == 0 || N_EVT > (1 << CODE_W)) begin : g_bad_n_evt
      $error("pmon_slice: N_EVT out of range for the event code");
   end

   cfg_t             cfg;
   logic [CFG_W-1:0] cfg_raw;
   logic             cfg_wr;
   logic             ctr_wr;
   logic [CTR_W-1:0] ctr_wval;
   logic [INC_W-1:0] raw_inc;
   logic [INC_W-1:0] step;
   logic             cnt_en;
   logic [CTR_W-1:0] ctr;

   assign cfg_wr   = wr_en_i && !wr_sel_i;
   assign ctr_wr   = wr_en_i &&  wr_sel_i;
   assign ctr_wval = wr_data_i[CTR_W-1:0];
   assign cnt_en   = glb_en_i && cfg.en;

   pmon_cfg_reg u_cfg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (cfg_wr),
      .wdata_i (wr_data_i),
      .cfg_o   (cfg),
      .raw_o   (cfg_raw)
   );

   pmon_evt_sel #(
      .N_EVT (N_EVT),
      .SUB_W (SUB_W),
      .INC_W (INC_W)
   ) u_sel (
      .evt_vec_i (evt_vec_i),
      .code_i    (cfg.code),
      .mask_i    (cfg.mask),
      .inc_o     (raw_inc)
   );

   pmon_filter #(
      .INC_W (INC_W)
   ) u_filt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .inc_i     (raw_inc),
      .thr_i     (cfg.thr),
      .inv_i     (cfg.inv),
      .edge_on_i (cfg.edge_on),
      .step_o    (step)
   );

   pmon_counter #(
      .CTR_W (CTR_W),
      .INC_W (INC_W)
   ) u_ctr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (ctr_wr),
      .wdata_i  (ctr_wval),
      .cnt_en_i (cnt_en),
      .step_i   (step),
      .irq_en_i (cfg.irq_en),
      .ctr_o    (ctr),
      .irq_o    (irq_o)
   );

   assign rd_data_o = rd_sel_i ? CFG_W'(ctr) : cfg_raw;

endmodule

// File: rtl/pmon_slice_chk.sv
`timescale 1ns/1ps
module pmon_slice_chk #(
   parameter int unsigned CTR_W = 48
)(
   input logic             clk_i,
   input logic             rst_ni,
   input logic             ctr_wr,
   input logic [CTR_W-1:0] ctr_wval,
   input logic             cnt_en,
   input logic             thr_nz,
   input logic             irq_en,
   input logic [CTR_W-1:0] ctr,
   input logic             irq
);

   // R11: a software load lands regardless of counting
   p_wr_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctr_wr |=> (ctr == $past(ctr_wval)));

   // R8: no load and no enable means no change
   p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctr_wr && !cnt_en) |=> $stable(ctr));

   // R5: thresholded counting moves by at most one
   p_unit_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctr_wr && cnt_en && thr_nz) |=>
         ((ctr == $past(ctr)) || (ctr == $past(ctr) + CTR_W'(1))));

   // R10: pulse only with the interrupt enable set
   p_irq_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq |-> $past(irq_en));

   // R10: the pulse lasts a single cycle
   p_irq_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq |=> !irq);

   // R9: a pulse coincides with a wrapped (smaller) counter value
   p_irq_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq |-> (ctr < $past(ctr)));

endmodule

bind pmon_slice pmon_slice_chk #(.CTR_W(CTR_W)) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .ctr_wr   (ctr_wr),
   .ctr_wval (ctr_wval),
   .cnt_en   (cnt_en),
   .thr_nz   (cfg.thr != '0),
   .irq_en   (cfg.irq_en),
   .ctr      (ctr),
   .irq      (irq_o)
);

// File: tb/pmon_slice_tb.sv
`timescale 1ns/1ps
module pmon_slice_tb_top;

   localparam int N_EVT = 4;
   localparam int SUB_W = 8;
   localparam int CTR_W = 48;
   localparam longint WD_CYCLES = 100000;
   localparam logic [63:0] CTR_MAX = 64'h0000_FFFF_FFFF_FFFF;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   glb_en = 1'b0;
   logic [N_EVT*SUB_W-1:0] evt = '0;
   logic                   wr_en = 1'b0;
   logic                   wr_sel = 1'b0;
   logic [63:0]            wr_data = '0;
   logic                   rd_sel = 1'b0;
   logic [63:0]            rd_data;
   logic                   irq;

   int  n_checks = 0;
   int  n_errs   = 0;
   bit  done     = 1'b0;

   always #4 clk = ~clk;

   pmon_slice #(.N_EVT(N_EVT), .SUB_W(SUB_W), .CTR_W(CTR_W)) dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .glb_en_i  (glb_en),
      .evt_vec_i (evt),
      .wr_en_i   (wr_en),
      .wr_sel_i  (wr_sel),
      .wr_data_i (wr_data),
      .rd_sel_i  (rd_sel),
      .rd_data_o (rd_data),
      .irq_o     (irq)
   );

   function automatic logic [63:0] mk_cfg(input logic [7:0] code, input logic [7:0] mask,
                                          input logic edge_on, input logic irq_en,
                                          input logic en, input logic inv,
                                          input logic [7:0] thr);
      logic [63:0] w;
      w = '0;
      w[7:0]   = code;
      w[15:8]  = mask;
      w[18]    = edge_on;
      w[20]    = irq_en;
      w[22]    = en;
      w[23]    = inv;
      w[31:24] = thr;
      return w;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic sel, input logic [63:0] data);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_reg(input logic sel, output logic [63:0] val);
      rd_sel = sel;
      #1;
      val = rd_data;
   endtask

   // Count for n cycles with a fixed event vector
   task automatic run(input logic [31:0] vec, input int n);
      evt = vec; glb_en = 1'b1;
      repeat (n) @(negedge clk);
      glb_en = 1'b0;
   endtask

   task automatic idle(input logic [31:0] vec, input int n);
      evt = vec; glb_en = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [63:0] v;
      rd_reg(1'b0, v); check("R1 cfg after reset", v, 64'h0);
      rd_reg(1'b1, v); check("R1 counter after reset", v, 64'h0);
      check("R1 irq after reset", {63'h0, irq}, 64'h0);
   endtask

   task automatic t_cfg_mask();
      logic [63:0] v;
      wr_reg(1'b0, '1);
      rd_reg(1'b0, v); check("R2 writable fields", v, 64'h0000_0000_FFD4_FFFF);
      wr_reg(1'b0, 64'h0);
      rd_reg(1'b0, v); check("R2 cleared", v, 64'h0);
   endtask

   task automatic t_select();
      logic [63:0] v;
      wr_reg(1'b0, mk_cfg(8'd2, 8'hF0, 0, 0, 1, 1, 8'd0));
      wr_reg(1'b1, 64'h0);
      run(32'hFFB7_FFFF, 5);   // slice2=B7 & F0 -> 3 bits
      rd_reg(1'b1, v); check("R3/R4 masked popcount raw add", v, 64'd15);
      wr_reg(1'b0, mk_cfg(8'd7, 8'hFF, 0, 0, 1, 0, 8'd0));
      run(32'hFFFF_FFFF, 5);
      rd_reg(1'b1, v); check("R3 code out of range adds zero", v, 64'd15);
   endtask

   task automatic t_thresh();
      logic [63:0] v;
      wr_reg(1'b0, mk_cfg(8'd0, 8'hFF, 0, 0, 1, 0, 8'd3));
      wr_reg(1'b1, 64'h0);
      run(32'h0000_0007, 4);   // 3 >= 3
      run(32'h0000_0003, 4);   // 2 < 3
      rd_reg(1'b1, v); check("R5 inclusive threshold", v, 64'd4);
   endtask

   task automatic t_invert();
      logic [63:0] v;
      wr_reg(1'b0, mk_cfg(8'd0, 8'hFF, 0, 0, 1, 1, 8'd3));
      wr_reg(1'b1, 64'h0);
      run(32'h0000_0007, 4);   // 3 not > 3
      rd_reg(1'b1, v); check("R6 equal value rejected", v, 64'd0);
      run(32'h0000_000F, 3);   // 4 > 3
      rd_reg(1'b1, v); check("R6 strict threshold", v, 64'd3);
   endtask

   task automatic t_edge();
      logic [63:0] v;
      wr_reg(1'b0, mk_cfg(8'd0, 8'hFF, 1, 0, 1, 0, 8'd0));
      wr_reg(1'b1, 64'h0);
      idle(32'h0, 2);
      run(32'h0000_001F, 4);
      run(32'h0, 1);
      run(32'h0000_001F, 2);
      rd_reg(1'b1, v); check("R7 edge on raw activity", v, 64'd2);
      wr_reg(1'b0, mk_cfg(8'd0, 8'hFF, 1, 0, 1, 0, 8'd4));
      wr_reg(1'b1, 64'h0);
      idle(32'h0, 2);
      run(32'h0000_001F, 1);   // 5: hit, rising
      run(32'h0000_003F, 1);   // 6: hit, held
      run(32'h0000_0003, 1);   // 2: miss
      run(32'h0000_000F, 1);   // 4: hit, rising
      rd_reg(1'b1, v); check("R7 edge after threshold", v, 64'd2);
   endtask

   task automatic t_enable();
      logic [63:0] v;
      wr_reg(1'b0, mk_cfg(8'd0, 8'hFF, 0, 0, 0, 0, 8'd0));
      wr_reg(1'b1, 64'd50);
      run(32'h0000_00FF, 5);
      rd_reg(1'b1, v); check("R8 local enable off", v, 64'd50);
      wr_reg(1'b0, mk_cfg(8'd0, 8'hFF, 0, 0, 1, 0, 8'd0));
      idle(32'h0000_00FF, 5);
      rd_reg(1'b1, v); check("R8 global enable off", v, 64'd50);
   endtask

   task automatic t_wrap_irq();
      logic [63:0] v;
      wr_reg(1'b0, mk_cfg(8'd0, 8'hFF, 0, 1, 1, 0, 8'd0));
      wr_reg(1'b1, CTR_MAX - 64'd2);
      evt = 32'h0000_0003; glb_en = 1'b1;
      @(negedge clk);
      rd_reg(1'b1, v); check("R12 live read near top", v, CTR_MAX);
      check("R10 no pulse before carry", {63'h0, irq}, 64'h0);
      @(negedge clk);
      rd_reg(1'b1, v); check("R9 wrapped value", v, 64'd1);
      check("R10 pulse with wrapped value", {63'h0, irq}, 64'h1);
      @(negedge clk);
      rd_reg(1'b1, v); check("R9 counting continues", v, 64'd3);
      check("R10 pulse is one cycle", {63'h0, irq}, 64'h0);
      glb_en = 1'b0;
      rd_reg(1'b0, v); check("R12 cfg readback", v, mk_cfg(8'd0, 8'hFF, 0, 1, 1, 0, 8'd0));
      wr_reg(1'b0, mk_cfg(8'd0, 8'hFF, 0, 0, 1, 0, 8'd0));
      wr_reg(1'b1, CTR_MAX);
      evt = 32'h0000_0001; glb_en = 1'b1;
      @(negedge clk);
      glb_en = 1'b0;
      rd_reg(1'b1, v); check("R9 wrap to zero", v, 64'd0);
      check("R10 pulse suppressed when disabled", {63'h0, irq}, 64'h0);
   endtask

   task automatic t_wr_prio();
      logic [63:0] v;
      wr_reg(1'b0, mk_cfg(8'd0, 8'hFF, 0, 1, 1, 0, 8'd0));
      wr_reg(1'b1, CTR_MAX);
      evt = 32'h0000_000F; glb_en = 1'b1;
      wr_en = 1'b1; wr_sel = 1'b1; wr_data = 64'd100;
      @(negedge clk);
      wr_en = 1'b0;
      rd_reg(1'b1, v); check("R11 write beats increment", v, 64'd100);
      check("R11 no pulse on write cycle", {63'h0, irq}, 64'h0);
      @(negedge clk);
      glb_en = 1'b0;
      rd_reg(1'b1, v); check("R11 counting resumes", v, 64'd104);
      check("R11 still no pulse", {63'h0, irq}, 64'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cfg_mask();
      t_select();
      t_thresh();
      t_invert();
      t_edge();
      t_enable();
      t_wrap_irq();
      t_wr_prio();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   initial begin
      #(WD_CYCLES * 8);
      if (!done) begin
         n_checks++;
         n_errs++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

endmodule